// File: doc/BRIEF.md
# Walsh-series waveform synthesizer

The block produces one sample of a periodic waveform by adding up a series of Walsh terms. For the current phase of the period, an external generator supplies one Walsh sign bit per term. The block applies each bit to the matching coefficient: a bit of 0 adds the coefficient to the running sum and a bit of 1 subtracts it. No multiplier is needed. Coefficients are signed Q1.15 values held in a bank that is written one entry at a time through an address/data/enable port.

Each sample is computed serially, one term per clock. A start request latches the sign bits and takes a snapshot of the coefficient bank. Coefficient writes therefore go to a staging copy and reach the arithmetic only from the next sample onward. The sum is held at full precision, so it cannot wrap. It is then clipped to a 16-bit signed sample, and the sample is announced with a single-cycle strobe. The caller repeats this for every phase step in the period.

Top module: `walsh_synth`

## Requirements
- R1: After reset, sample_o is 0, valid_o and busy_o are 0, and every coefficient is 0. A sample computed before any write is therefore 0.
- R2: The sample is the sum over n of s_n·A_n. A_n is the coefficient written at address n. s_n is +1 when walsh_i[n] is 0 and -1 when walsh_i[n] is 1.
- R3: The sum is formed at full precision and then clipped to the 16-bit signed range. A sum above 32767 gives 32767, and a sum below -32768 gives -32768.
- R4: valid_o is high for exactly one cycle. It rises on the 64th rising edge after the edge that accepted start_i, and that same edge brings the new sample_o. busy_o is high from the accepting edge until that edge.
- R5: start_i is ignored while busy_o is high. No second sample starts and no extra valid_o pulse follows.
- R6: walsh_i is sampled only on the accepting edge. Changes to it during the accumulation do not alter the result.
- R7: A coefficient write made while a sample is in progress does not affect that sample. It takes effect from the next accepted start.
- R8: sample_o holds its value between valid_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one sample; accepted when busy_o is low |
| walsh_i | input | 64 | Walsh sign bit per term for the current phase |
| wr_en_i | input | 1 | Coefficient write enable |
| wr_addr_i | input | 6 | Coefficient index |
| wr_data_i | input | 16 | Coefficient value, signed Q1.15 |
| busy_o | output | 1 | Accumulation in progress |
| sample_o | output | 16 | Clipped signed sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench builds the block with its default parameters: 64 terms, 16-bit coefficients and a 16-bit output. This puts the full 64-cycle latency and the largest possible sums within reach. With every coefficient at either extreme and uniform sign bits, the sum reaches about ±2^21, which drives both clip limits. The worst case, -32768 subtracted 64 times, tests that the accumulator is wide enough. Mid-run disturbances are placed in the middle of the 64-cycle window: a second start, inverted sign bits and a coefficient write.

// File: rtl/wsyn_pkg.sv
package wsyn_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} wsyn_state_e;
endpackage

// File: rtl/wsyn_coef_bank.sv
module wsyn_coef_bank #(
  parameter int N_TERMS = 64,
  parameter int COEF_W  = 16,
  localparam int IDX_W  = $clog2(N_TERMS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [COEF_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [COEF_W-1:0] rd_data_o
);
  logic [COEF_W-1:0] stg_q [N_TERMS];
  logic [COEF_W-1:0] act_q [N_TERMS];

  for (genvar g = 0; g < N_TERMS; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else if (wr_en_i && (wr_addr_i == IDX_W'(g))) stg_q[g] <= wr_data_i;
    end
    // snapshot used by the arithmetic; updated only on an accepted start
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_q[g] <= '0;
      else if (load_i) act_q[g] <= stg_q[g];
    end
  end

  assign rd_data_o = act_q[rd_idx_i];
endmodule

// File: rtl/wsyn_term_sel.sv
module wsyn_term_sel #(
  parameter int N_TERMS = 64,
  parameter int COEF_W  = 16,
  localparam int IDX_W  = $clog2(N_TERMS),
  localparam int ACC_W  = COEF_W + IDX_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [N_TERMS-1:0]      walsh_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [COEF_W-1:0]       coef_i,
  output logic signed [ACC_W-1:0] term_o
);
  logic [N_TERMS-1:0]      wbits_q;
  logic signed [ACC_W-1:0] ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wbits_q <= '0;
    else if (load_i) wbits_q <= walsh_i;
  end

  assign ext    = {{(ACC_W-COEF_W){coef_i[COEF_W-1]}}, coef_i};
  assign term_o = wbits_q[idx_i] ? -ext : ext;
endmodule

// File: rtl/wsyn_ctrl.sv
module wsyn_ctrl #(
  parameter int N_TERMS = 64,
  localparam int IDX_W  = $clog2(N_TERMS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o
);
  import wsyn_pkg::*;
  wsyn_state_e     state_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign last_o = step_o && (idx_q == IDX_W'(N_TERMS-1));
  assign idx_o  = idx_q;
  assign busy_o = step_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (load_o) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
    end else if (step_o) begin
      idx_q <= idx_q + 1'b1;
      if (last_o) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/wsyn_accum.sv
module wsyn_accum #(
  parameter int N_TERMS = 64,
  parameter int COEF_W  = 16,
  parameter int OUT_W   = 16,
  localparam int IDX_W  = $clog2(N_TERMS),
  localparam int ACC_W  = COEF_W + IDX_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    step_i,
  input  logic                    last_i,
  input  logic signed [ACC_W-1:0] term_i,
  output logic [OUT_W-1:0]        sample_o,
  output logic                    valid_o
);
  localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((2**(OUT_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] MIN_V = -ACC_W'(2**(OUT_W-1));

  logic signed [ACC_W-1:0] acc_q, sum, clip;
  logic [OUT_W-1:0]        sample_q;
  logic                    valid_q;

  assign sum = acc_q + term_i;

  always_comb begin
    if (sum > MAX_V)      clip = MAX_V;
    else if (sum < MIN_V) clip = MIN_V;
    else                  clip = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= step_i && last_i;
      if (clear_i)     acc_q <= '0;
      else if (step_i) acc_q <= sum;
      if (step_i && last_i) sample_q <= clip[OUT_W-1:0];
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/walsh_synth.sv
module walsh_synth #(
  parameter int N_TERMS = 64,
  parameter int COEF_W  = 16,
  parameter int OUT_W   = 16,
  localparam int IDX_W  = $clog2(N_TERMS),
  localparam int ACC_W  = COEF_W + IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_TERMS-1:0] walsh_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_addr_i,
  input  logic [COEF_W-1:0]  wr_data_i,
  output logic               busy_o,
  output logic [OUT_W-1:0]   sample_o,
  output logic               valid_o
);
  logic                    load, step, last;
  logic [IDX_W-1:0]        idx;
  logic [COEF_W-1:0]       coef;
  logic signed [ACC_W-1:0] term;

  wsyn_ctrl #(.N_TERMS(N_TERMS)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .step_o(step), .last_o(last), .idx_o(idx), .busy_o
  );

  wsyn_coef_bank #(.N_TERMS(N_TERMS), .COEF_W(COEF_W)) u_bank (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(load), .rd_idx_i(idx), .rd_data_o(coef)
  );

  wsyn_term_sel #(.N_TERMS(N_TERMS), .COEF_W(COEF_W)) u_term (
    .clk_i, .rst_ni, .load_i(load), .walsh_i,
    .idx_i(idx), .coef_i(coef), .term_o(term)
  );

  wsyn_accum #(.N_TERMS(N_TERMS), .COEF_W(COEF_W), .OUT_W(OUT_W)) u_acc (
    .clk_i, .rst_ni, .clear_i(load), .step_i(step), .last_i(last),
    .term_i(term), .sample_o, .valid_o
  );
endmodule

// File: rtl/wsyn_checker.sv
module wsyn_checker #(
  parameter int N_TERMS = 64,
  parameter int OUT_W   = 16,
  localparam int CNT_W  = $clog2(N_TERMS) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic [OUT_W-1:0] sample_o,
  input logic             valid_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i && !busy_o) cnt_q <= '0;
    else if (busy_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cnt_q == CNT_W'(N_TERMS)) && !busy_o);
  a_r4_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r5_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q < CNT_W'(N_TERMS)));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o));
endmodule

bind walsh_synth wsyn_checker #(.N_TERMS(N_TERMS), .OUT_W(OUT_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .sample_o, .valid_o
);

// File: tb/walsh_synth_test.sv
module walsh_synth_test;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] walsh = '0;
  logic         wr_en = 1'b0;
  logic [5:0]   wr_addr = '0;
  logic [15:0]  wr_data = '0;
  logic         busy, valid;
  logic [15:0]  sample;

  int checks = 0, errors = 0;
  int stg [N];
  int act [N];
  bit done = 0;

  always #5 clk = ~clk;

  walsh_synth uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .walsh_i(walsh),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .busy_o(busy), .sample_o(sample), .valid_o(valid)
  );

  task automatic check(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  function automatic int expect_sum(input logic [N-1:0] w);
    int s = 0;
    for (int n = 0; n < N; n++) s += w[n] ? -act[n] : act[n];
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic write_coef(input int a, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 16'(v);
    @(negedge clk);
    wr_en = 1'b0;
    stg[a] = v;
  endtask

  // mode 0 plain, 1 flip walsh mid-run, 2 extra start mid-run, 3 write mid-run
  task automatic run_sample(input logic [N-1:0] w, input int mode, input string req);
    int lat = 0;
    int exp_v;
    @(negedge clk);
    start = 1'b1; walsh = w;
    @(posedge clk);
    for (int n = 0; n < N; n++) act[n] = stg[n];
    exp_v = expect_sum(w);
    @(negedge clk);
    start = 1'b0;
    check({req, " R4 busy after start"}, int'(busy), 1);
    for (int k = 1; k <= 80; k++) begin
      if (k == 10) begin
        if (mode == 1) walsh = ~w;
        if (mode == 2) start = 1'b1;
        if (mode == 3) begin
          wr_en = 1'b1; wr_addr = 6'd5; wr_data = 16'sd1234;
        end
      end
      if (k == 11) begin
        start = 1'b0;
        if (mode == 3) begin wr_en = 1'b0; stg[5] = 1234; end
      end
      @(posedge clk); #1;
      if (valid) begin lat = k; break; end
    end
    check({req, " R4 latency"}, lat, N);
    check({req, " value"}, int'($signed(sample)), exp_v);
    check({req, " R4 busy low at valid"}, int'(busy), 0);
    @(posedge clk); #1;
    check({req, " R4 valid one cycle"}, int'(valid), 0);
  endtask

  task automatic t_reset;
    check("R1 reset sample", int'(sample), 0);
    check("R1 reset valid", int'(valid), 0);
    check("R1 reset busy", int'(busy), 0);
    run_sample(64'hA5A5_0F0F_3C3C_FFFF, 0, "R1 zero bank");
  endtask

  task automatic t_sum;
    for (int n = 0; n < N; n++) write_coef(n, ((n * 523) % 2001) - 1000);
    run_sample('0, 0, "R2 all add");
    run_sample('1, 0, "R2 all subtract");
    run_sample(64'h5555_5555_5555_5555, 0, "R2 alternating");
    run_sample(64'h0123_4567_89AB_CDEF, 0, "R2 mixed");
  endtask

  task automatic t_sat;
    for (int n = 0; n < N; n++) write_coef(n, 32767);
    run_sample('0, 0, "R3 positive clip");
    run_sample('1, 0, "R3 negative clip");
    for (int n = 0; n < N; n++) write_coef(n, -32768);
    run_sample('1, 0, "R3 max magnitude clip");
    run_sample('0, 0, "R3 min clip");
    for (int n = 0; n < N; n++) write_coef(n, 0);
    write_coef(0, 32767); write_coef(1, 1);
    run_sample(64'h2, 0, "R3 just inside");
  endtask

  task automatic t_busy;
    for (int n = 0; n < N; n++) write_coef(n, (n % 7) * 100 - 300);
    run_sample(64'hF0F0_0000_FFFF_1234, 2, "R5 restart ignored");
    for (int k = 0; k < 80; k++) begin
      @(posedge clk); #1;
      if (valid || busy) begin check("R5 no extra sample", 1, 0); break; end
    end
    check("R8 sample held", int'($signed(sample)), expect_sum(64'hF0F0_0000_FFFF_1234));
    run_sample(64'h00FF_00FF_00FF_00FF, 1, "R6 walsh latched");
    run_sample(64'h0000_0000_0000_0000, 3, "R7 write deferred");
    run_sample(64'h0000_0000_0000_0000, 0, "R7 write applied");
  endtask

  initial begin
    for (int n = 0; n < N; n++) begin stg[n] = 0; act[n] = 0; end
    #23 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sum();
    t_sat();
    t_busy();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule